// File: doc/BRIEF.md
# Four-Channel Double-Buffered PWM Generator

This block drives four pulse-width-modulated outputs from a slow reference tick. The tick is a single-cycle strobe on the system clock. Each channel has three registers on a single-cycle write and registered-read port: a period count, a high-time (duty) count and a control word. The control word picks a power-of-two tick divider and the output polarity. Software writes go only into shadow copies. The running waveform takes them up as one set, and only after the period register has been written and the current period has run out. This means a reconfiguration never produces a truncated or mixed pulse.

Each channel counts prescaled ticks from zero up to its period minus one. The output is at its active level while the count is below the duty value. Writing a zero period stops the channel cleanly: the period in flight finishes, and the pin then stays low whatever the polarity. An idle channel that is given a nonzero period starts at once, without waiting for a boundary.

Top module: `pwm4_shadowed`

## Requirements
- R1: While and after a synchronous active-high reset, every output is low and every mapped register reads back zero.
- R2: Register map with a 12-bit byte address and channel c in 0..3. The period is at 0x400+4c, the duty at 0x420+4c and the control word at 0x440+4c. Reads return the last value written, one cycle after the address is presented. Control keeps only bits [1:0] (divider select) and bit 5 (invert); its other bits read as zero.
- R3: Any other address reads as zero, and a write to it changes no register and no output. This includes channel slots 4..7 (such as 0x410) and addresses that are not word aligned.
- R4: When a channel is running with period P>0 and duty D, its output repeats every P prescaled ticks. In each repetition the output is active for min(D,P) prescaled ticks.
- R5: Divider select value s makes one prescaled tick equal to 2^s reference ticks, for s in 0..3.
- R6: Control bit 5 set makes the active level low instead of high.
- R7: A duty of 0 gives a constant inactive level. A duty of P or more gives a constant active level.
- R8: Duty and control writes without a later period write never reach the output.
- R9: After a period write to a running channel, the current period finishes with the old settings. The new period, duty and control then take effect together from the next period.
- R10: A zero period write lets the current period complete, after which the output is held low regardless of polarity.
- R11: On an idle channel, a nonzero period write loads the shadow settings at once. The output shows the new waveform within one reference-tick interval.
- R12: The four channels run independently with their own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Single-cycle reference tick strobe |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Byte address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, for the address of the previous cycle |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The bench measures each output's high time over a whole number of periods, so the result does not depend on phase. This catches a wrong divider, a counter that runs one step long or short, and a polarity that is applied the wrong way round. Duty and control changes made with no period write must leave the measured waveform unchanged; a design that commits on any register write would show the new duty early. Around a period write made right after a period begins, the bench counts the rest of that period separately from the one that follows. A design that switches at once would shorten the pulse in flight, and one that ignores the disable would keep toggling. Duty extremes and unmapped or misaligned addresses are driven directly: a decoder that aliases channel slots 4..7 would corrupt channels 0..3.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int CTRL_INV_BIT = 5;
  localparam logic [6:0] GRP_PERIOD = 7'h20;
  localparam logic [6:0] GRP_DUTY   = 7'h21;
  localparam logic [6:0] GRP_CTRL   = 7'h22;

  typedef struct packed {
    logic       inv;
    logic [1:0] div;
  } ctrl_t;

  typedef enum logic [1:0] {SEL_NONE, SEL_PERIOD, SEL_DUTY, SEL_CTRL} sel_e;
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 16,
  parameter int AW  = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic [AW-1:0]             addr,
  input  logic [PW-1:0]             wdata,
  output logic [PW-1:0]             rdata,
  output logic [NCH-1:0][PW-1:0]    sh_period,
  output logic [NCH-1:0][PW-1:0]    sh_duty,
  output ctrl_t [NCH-1:0]           sh_ctrl,
  output logic [NCH-1:0]            period_wr
);
  localparam int GW  = AW - 5;
  localparam int CHW = 3;

  logic [GW-1:0]  grp;
  logic [CHW-1:0] ch;
  sel_e           sel;
  logic [PW-1:0]  rd_next;

  assign grp = addr[AW-1:5];
  assign ch  = addr[4:2];

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00 && int'(ch) < NCH) begin
      if (grp == GW'(GRP_PERIOD))    sel = SEL_PERIOD;
      else if (grp == GW'(GRP_DUTY)) sel = SEL_DUTY;
      else if (grp == GW'(GRP_CTRL)) sel = SEL_CTRL;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_shadow
    logic hit_c;
    assign hit_c        = wr && (ch == CHW'(c));
    assign period_wr[c] = hit_c && (sel == SEL_PERIOD);

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_period[c] <= '0;
        sh_duty[c]   <= '0;
        sh_ctrl[c]   <= '0;
      end else if (hit_c) begin
        case (sel)
          SEL_PERIOD: sh_period[c] <= wdata;
          SEL_DUTY:   sh_duty[c]   <= wdata;
          SEL_CTRL:   sh_ctrl[c]   <= '{inv: wdata[CTRL_INV_BIT], div: wdata[1:0]};
          default:    ;
        endcase
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch == CHW'(c)) begin
        case (sel)
          SEL_PERIOD: rd_next = sh_period[c];
          SEL_DUTY:   rd_next = sh_duty[c];
          SEL_CTRL: begin
            rd_next[CTRL_INV_BIT] = sh_ctrl[c].inv;
            rd_next[1:0]          = sh_ctrl[c].div;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R3: writes outside the map leave every shadow register untouched
  p_unmapped_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_NONE) |=> ($stable(sh_period) && $stable(sh_duty) && $stable(sh_ctrl)));

  // R3: unmapped reads return zero on the following cycle
  p_unmapped_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (rdata == '0));
endmodule

// File: rtl/pwm4_prescale.sv
module pwm4_prescale #(
  parameter int DIVW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            clr,
  input  logic [DIVW-1:0] div,
  output logic            ptick
);
  localparam int PREW = (1 << DIVW) - 1;

  logic [PREW-1:0] pre;
  logic [PREW-1:0] mask;

  assign mask  = PREW'((1 << div) - 1);
  assign ptick = tick && (pre == mask);

  always_ff @(posedge clk) begin
    if (rst || clr)  pre <= '0;
    else if (ptick)  pre <= '0;
    else if (tick)   pre <= pre + 1'b1;
  end

  // R5: the tick count never runs past the selected divide ratio
  p_pre_in_range_r5: assert property (@(posedge clk) disable iff (rst)
    pre <= mask);
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
  import pwm4_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          period_wr,
  input  logic [PW-1:0] sh_period,
  input  logic [PW-1:0] sh_duty,
  input  ctrl_t         sh_ctrl,
  output logic          pwm
);
  logic          en;
  logic          pend;
  logic [PW-1:0] a_period;
  logic [PW-1:0] a_duty;
  ctrl_t         a_ctrl;
  logic [PW-1:0] cnt;
  logic          ptick;
  logic          bound;
  logic          commit;

  pwm4_prescale #(.DIVW(2)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick && en),
    .clr   (commit),
    .div   (a_ctrl.div),
    .ptick (ptick)
  );

  assign bound  = en && ptick && (cnt == a_period - 1'b1);
  assign commit = pend && (!en || bound);

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      pend     <= 1'b0;
      a_period <= '0;
      a_duty   <= '0;
      a_ctrl   <= '0;
      cnt      <= '0;
      pwm      <= 1'b0;
    end else begin
      if (period_wr)   pend <= 1'b1;
      else if (commit) pend <= 1'b0;

      if (commit) begin
        a_period <= sh_period;
        a_duty   <= sh_duty;
        a_ctrl   <= sh_ctrl;
        en       <= (sh_period != '0);
        cnt      <= '0;
      end else if (bound) begin
        cnt <= '0;
      end else if (en && ptick) begin
        cnt <= cnt + 1'b1;
      end

      pwm <= en && ((cnt < a_duty) ^ a_ctrl.inv);
    end
  end

  // R4: the counter stays inside the active period while running
  p_cnt_in_period_r4: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < a_period));

  // R9: active settings only move on a commit
  p_hold_until_commit_r9: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(a_period) && $stable(a_duty) && $stable(a_ctrl)));

  // R10: a stopped channel drives low on the next cycle
  p_disabled_low_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm);
endmodule

// File: rtl/pwm4_shadowed.sv
module pwm4_shadowed
  import pwm4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 16,
  parameter int AW  = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [PW-1:0]  bus_wdata,
  output logic [PW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  logic [NCH-1:0][PW-1:0] sh_period;
  logic [NCH-1:0][PW-1:0] sh_duty;
  ctrl_t [NCH-1:0]        sh_ctrl;
  logic [NCH-1:0]         period_wr;

  pwm4_regs #(.NCH(NCH), .PW(PW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .sh_period (sh_period),
    .sh_duty   (sh_duty),
    .sh_ctrl   (sh_ctrl),
    .period_wr (period_wr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm4_chan #(.PW(PW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .period_wr (period_wr[c]),
      .sh_period (sh_period[c]),
      .sh_duty   (sh_duty[c]),
      .sh_ctrl   (sh_ctrl[c]),
      .pwm       (pwm_out[c])
    );
  end
endmodule

// File: tb/tb_pwm4_shadowed.sv
module tb_pwm4_shadowed;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  pwm_out;

  int          n_tests = 0;
  int          n_fail = 0;
  logic [3:0]  smp = '0;
  int unsigned nsmp = 0;
  int          cur_len [4] = '{0, 0, 0, 0};

  pwm4_shadowed dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm_out)
  );

  always #2 clk = ~clk;

  // tick every 4 clocks; the outputs are sampled once per tick interval
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      smp = pwm_out;
      nsmp++;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_s();
    int unsigned n0 = nsmp;
    wait (nsmp != n0);
  endtask

  task automatic bwr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, output int d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = int'(rdata);
  endtask

  function automatic int exp_hi(int p, int d, int s, int inv, int l);
    int len, hi;
    if (p == 0) return 0;
    len = p << s;
    hi = ((d < p) ? d : p) << s;
    hi = hi * (l / len);
    return (inv != 0) ? (l - hi) : hi;
  endfunction

  task automatic measure(input int ch, input int l, output int hi);
    hi = 0;
    for (int i = 0; i < l; i++) begin
      wait_s();
      hi += int'(smp[ch]);
    end
  endtask

  task automatic cfg(input int ch, input int p, input int d, input int s, input int inv);
    bwr(12'h440 + 12'(4 * ch), 16'((inv << 5) | s));
    bwr(12'h420 + 12'(4 * ch), 16'(d));
    bwr(12'h400 + 12'(4 * ch), 16'(p));
  endtask

  task automatic settle(input int ch, input int new_len);
    repeat (cur_len[ch] + 3) wait_s();
    cur_len[ch] = new_len;
  endtask

  task automatic run_case(input string req, input int ch, input int p, input int d,
                          input int s, input int inv);
    int hi, l;
    cfg(ch, p, d, s, inv);
    settle(ch, p << s);
    l = (p == 0) ? 16 : 2 * (p << s);
    measure(ch, l, hi);
    chk(req, hi, exp_hi(p, d, s, inv, l));
  endtask

  task automatic wait_start(input int ch, input int inv);
    logic prv, cur;
    wait_s();
    cur = smp[ch] ^ inv[0];
    for (int i = 0; i < 400; i++) begin
      prv = cur;
      wait_s();
      cur = smp[ch] ^ inv[0];
      if (!prv && cur) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int v, hi;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    wait_s(); wait_s();
    chk("R1 outputs", int'(smp), 0);
    brd(12'h400, v); chk("R1 period ch0", v, 0);
    brd(12'h42C, v); chk("R1 duty ch3", v, 0);
    brd(12'h444, v); chk("R1 ctrl ch1", v, 0);

    // R2: readback of shadow values and control masking
    bwr(12'h444, 16'hFFFF);
    brd(12'h444, v); chk("R2 ctrl mask", v, 16'h0023);
    bwr(12'h428, 16'hABCD);
    brd(12'h428, v); chk("R2 duty readback", v, 16'hABCD);
    bwr(12'h444, 16'h0000);
    bwr(12'h428, 16'h0000);

    // R3: unmapped addresses
    brd(12'h460, v); chk("R3 read 0x460", v, 0);
    bwr(12'h410, 16'h0005);
    bwr(12'h402, 16'h0007);
    brd(12'h410, v); chk("R3 read slot 4", v, 0);
    brd(12'h402, v); chk("R3 read misaligned", v, 0);
    brd(12'h400, v); chk("R3 ch0 period untouched", v, 0);
    wait_s(); wait_s();
    chk("R3 outputs still idle", int'(smp), 0);

    // R11: idle start
    cfg(0, 10, 5, 0, 0);
    wait_s(); wait_s();
    chk("R11 idle start high", int'(smp[0]), 1);
    settle(0, 10);

    // R4..R7 directed waveforms
    run_case("R4 basic", 0, 12, 4, 0, 0);
    run_case("R5 div4", 0, 12, 4, 2, 0);
    run_case("R5 div8", 0, 5, 2, 3, 0);
    run_case("R6 inverted", 0, 12, 4, 1, 1);
    run_case("R7 duty zero", 0, 9, 0, 0, 0);
    run_case("R7 duty over period", 0, 9, 20, 3, 0);
    run_case("R7 inverted duty zero", 0, 7, 0, 0, 1);
    run_case("R4 period one", 0, 1, 1, 1, 0);

    // R12: independent channels with random settings
    for (int r = 0; r < 8; r++) begin
      int p [4], d [4], s [4], iv [4];
      int mx = 0;
      for (int c = 0; c < 4; c++) begin
        p[c]  = 1 + int'($urandom_range(23));
        d[c]  = int'($urandom_range(28));
        s[c]  = int'($urandom_range(3));
        iv[c] = int'($urandom_range(1));
        if (cur_len[c] > mx) mx = cur_len[c];
        cfg(c, p[c], d[c], s[c], iv[c]);
      end
      repeat (mx + 3) wait_s();
      for (int c = 0; c < 4; c++) begin
        cur_len[c] = p[c] << s[c];
        measure(c, 2 * cur_len[c], hi);
        chk($sformatf("R12 round %0d ch%0d", r, c), hi,
            exp_hi(p[c], d[c], s[c], iv[c], 2 * cur_len[c]));
      end
    end

    // R8: duty/control writes without a period write stay shadowed
    cfg(2, 16, 4, 0, 0);
    settle(2, 16);
    bwr(12'h428, 16'd12);
    bwr(12'h448, 16'h0000);
    repeat (40) wait_s();
    measure(2, 32, hi); chk("R8 old duty kept", hi, 8);
    bwr(12'h408, 16'd16);
    repeat (20) wait_s();
    measure(2, 32, hi); chk("R8 new duty after period write", hi, 24);

    // R9: current period completes with old settings, then switches
    cfg(1, 16, 4, 0, 0);
    settle(1, 16);
    bwr(12'h424, 16'd12);
    wait_start(1, 0);
    bwr(12'h404, 16'd16);
    measure(1, 15, hi); chk("R9 rest of old period", hi, 3);
    measure(1, 16, hi); chk("R9 first new period", hi, 12);

    // R10: disable completes the period, then low
    cfg(3, 16, 6, 0, 0);
    settle(3, 16);
    wait_start(3, 0);
    bwr(12'h40C, 16'd0);
    measure(3, 15, hi); chk("R10 period finishes", hi, 5);
    measure(3, 32, hi); chk("R10 held low", hi, 0);
    cur_len[3] = 0;
    cfg(3, 16, 6, 0, 1);
    settle(3, 16);
    wait_start(3, 1);
    bwr(12'h40C, 16'd0);
    measure(3, 15, hi); chk("R10 inverted period finishes", hi, 10);
    measure(3, 32, hi); chk("R10 inverted held low", hi, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule